// File: doc/BRIEF.md
# DMA Channel Loop Sequencer

This block steps one DMA channel through its transfer. The transfer is built from two nested loops. The inner loop, called the minor loop, runs once for each service request. It moves a set number of bytes as pairs of accesses: one read beat, then one write beat. The outer loop, called the major loop, counts the minor loops down from a programmed start value.

When the count runs out, the sequencer does four things:
- it reloads the count from the start value;
- it sets a sticky done flag;
- it can raise a completion interrupt;
- it can drop its hardware request enable.

The sequencer can also:
- raise an interrupt half way through the major loop;
- emit a start pulse to a linked channel after every minor loop, or only at the end of the major loop;
- insert a programmable idle gap after every access;
- halt on an error, so that later requests are ignored.

A minor loop can be started by a hardware request (when requests are enabled) or by a software start strobe. In continuous mode, a channel that links to itself on every minor loop starts its next minor loop by itself.

The read and write beats use valid/ready handshakes. `rd_valid` or `wr_valid` stays high, with no change, until the matching ready is seen at a clock edge. A low ready stalls the sequencer for as long as it stays low. Address generation and the bus protocol are outside this block.

Top module: `dma_loop_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `rd_valid`, `wr_valid`, `req_en`, `halted`, `done`, all pulse outputs are 0 and `citer` is 0.
- R2: Once raised, `rd_valid` (or `wr_valid`) stays high until a cycle in which `rd_ready` (or `wr_ready`) is high; a low ready holds the sequencer in place.
- R3: While idle, `sw_start`, or `hw_req` with `req_en` high, starts one minor loop. The loop has max(1, `cfg_nbytes`/BEAT_BYTES) beats, and each beat is a read handshake followed by a write handshake. `hw_req` with `req_en` low, and any start while busy, is ignored.
- R4: `iter_load` copies `cfg_biter` into `citer`. At the end of each minor loop, `citer` decreases by 1.
- R5: A minor loop that ends with `citer` at 1 (or 0) exhausts the major loop. It reloads `citer` from `cfg_biter`, sets `done`, and, if `cfg_major_irq_en` is set, pulses `irq_major` for one cycle. `done` stays set until `done_clr`.
- R6: If `cfg_half_irq_en` is set and `cfg_biter`/2 is nonzero, `irq_half` pulses for one cycle when `citer` decrements to `cfg_biter`/2.
- R7: `cfg_link_mode` 0 gives no link pulse. Mode 1 pulses `link_start` after every minor loop. Mode 2 pulses it only when the major loop is exhausted. Each pulse presents `cfg_link_ch` on `link_ch_out`.
- R8: `cfg_bwc` sets an idle gap after every read and every write handshake, during which both valids are low. Code 2 gives 4 cycles, code 3 gives 8 cycles, and codes 0 and 1 give none. So one beat lasts 2+2·gap cycles when ready is always high.
- R9: With `cfg_auto_stop` set, an exhausted major loop clears `req_en`. `erq_set` sets `req_en` and `erq_clr` clears it.
- R10: With `cfg_cont_link` set, link mode 1 and `cfg_link_ch` equal to OWN_CH, a minor loop that does not exhaust the major loop is followed at once by the next minor loop, with no new request.
- R11: With `cfg_halt_on_err` set, `err_in` sets `halted`. While halted, all starts are ignored until `halt_clr`. A loop already running completes. `err_in` has no effect while `cfg_halt_on_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_nbytes | input | NB_W | Bytes per minor loop |
| cfg_biter | input | CNT_W | Start value of the major loop count |
| cfg_bwc | input | 2 | Gap code after each access |
| cfg_link_mode | input | 2 | 0 none, 1 every minor loop, 2 major end |
| cfg_link_ch | input | CH_W | Channel to start on a link |
| cfg_cont_link | input | 1 | Continuous self-link enable |
| cfg_auto_stop | input | 1 | Clear request enable at major end |
| cfg_major_irq_en | input | 1 | Major completion interrupt enable |
| cfg_half_irq_en | input | 1 | Half-way interrupt enable |
| cfg_halt_on_err | input | 1 | Halt on error enable |
| iter_load | input | 1 | Load `citer` from `cfg_biter` |
| sw_start | input | 1 | Software start strobe |
| hw_req | input | 1 | Hardware service request |
| erq_set | input | 1 | Set request enable |
| erq_clr | input | 1 | Clear request enable |
| done_clr | input | 1 | Clear done flag |
| halt_clr | input | 1 | Clear halt flag |
| err_in | input | 1 | Error event |
| rd_valid | output | 1 | Read beat request |
| rd_ready | input | 1 | Read beat accepted |
| wr_valid | output | 1 | Write beat request |
| wr_ready | input | 1 | Write beat accepted |
| busy | output | 1 | Minor loop in progress |
| req_en | output | 1 | Hardware request enable |
| halted | output | 1 | Halt flag |
| citer | output | CNT_W | Remaining major loop count |
| done | output | 1 | Major loop done flag |
| irq_major | output | 1 | Major completion pulse |
| irq_half | output | 1 | Half-way pulse |
| link_start | output | 1 | Linked channel start pulse |
| link_ch_out | output | CH_W | Linked channel number |

## Verification
Each fault in the beat state machine shows up at the ports within one minor loop:
- a beat counter that is off by one changes the number of read and write handshakes;
- a gap counter that is wrong changes the number of `busy` cycles, which the bench counts exactly for each gap code;
- an iteration counter that is wrong shows up in `citer` in the cycle after the minor loop ends;
- a missed or early exhaustion shows up in `done`, `irq_major` and the link pulse count, at the latest one full major loop later.

Flags that block starts (`halted`, `req_en`) are checked by issuing a start while the flag is set and confirming that no read handshake follows.

// File: rtl/dmaseq_pkg.sv
package dmaseq_pkg;
  localparam int GAP_W = 4;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD,
    S_RD_GAP,
    S_WR,
    S_WR_GAP
  } seq_state_e;

  localparam logic [1:0] LINK_NONE  = 2'd0;
  localparam logic [1:0] LINK_MINOR = 2'd1;
  localparam logic [1:0] LINK_MAJOR = 2'd2;

  // idle cycles inserted after every access for a gap code
  function automatic logic [GAP_W-1:0] gap_cycles(input logic [1:0] code);
    case (code)
      2'd2:    return GAP_W'(4);
      2'd3:    return GAP_W'(8);
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/dma_beat_engine.sv
module dma_beat_engine
  import dmaseq_pkg::*;
#(
  parameter int NB_W       = 16,
  parameter int BEAT_BYTES = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            again,
  input  logic [NB_W-1:0] nbytes,
  input  logic [1:0]      bwc,
  output logic            rd_valid,
  input  logic            rd_ready,
  output logic            wr_valid,
  input  logic            wr_ready,
  output logic            busy,
  output logic            minor_end
);
  localparam int SHIFT = $clog2(BEAT_BYTES);

  seq_state_e          state_q;
  logic [NB_W-1:0]     beats_left_q;
  logic [GAP_W-1:0]    gap_q;
  logic [NB_W-1:0]     beat_raw, beat_total;
  logic [GAP_W-1:0]    gap_len;
  logic                last_beat, wr_done_nogap, gap_end;

  assign beat_raw   = nbytes >> SHIFT;
  assign beat_total = (beat_raw == '0) ? NB_W'(1) : beat_raw;
  assign gap_len    = gap_cycles(bwc);
  assign last_beat  = (beats_left_q == NB_W'(1));

  assign rd_valid = (state_q == S_RD);
  assign wr_valid = (state_q == S_WR);
  assign busy     = (state_q != S_IDLE);

  assign wr_done_nogap = (state_q == S_WR) && wr_ready && (gap_len == '0);
  assign gap_end       = (state_q == S_WR_GAP) && (gap_q == GAP_W'(1));
  assign minor_end     = (wr_done_nogap || gap_end) && last_beat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= S_IDLE;
      beats_left_q <= '0;
      gap_q        <= '0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          state_q      <= S_RD;
          beats_left_q <= beat_total;
        end
        S_RD: if (rd_ready) begin
          if (gap_len != '0) begin
            state_q <= S_RD_GAP;
            gap_q   <= gap_len;
          end else begin
            state_q <= S_WR;
          end
        end
        S_RD_GAP: begin
          gap_q <= gap_q - GAP_W'(1);
          if (gap_q == GAP_W'(1)) state_q <= S_WR;
        end
        S_WR: if (wr_ready) begin
          if (gap_len != '0) begin
            state_q <= S_WR_GAP;
            gap_q   <= gap_len;
          end else if (last_beat) begin
            state_q      <= again ? S_RD : S_IDLE;
            beats_left_q <= beat_total;
          end else begin
            state_q      <= S_RD;
            beats_left_q <= beats_left_q - NB_W'(1);
          end
        end
        S_WR_GAP: begin
          gap_q <= gap_q - GAP_W'(1);
          if (gap_q == GAP_W'(1)) begin
            if (last_beat) begin
              state_q      <= again ? S_RD : S_IDLE;
              beats_left_q <= beat_total;
            end else begin
              state_q      <= S_RD;
              beats_left_q <= beats_left_q - NB_W'(1);
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assert_hold_rd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid);
  assert_hold_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid);
  assert_write_follows_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid ##1 wr_valid |-> $past(state_q == S_RD_GAP || (rd_valid && rd_ready)));
endmodule

// File: rtl/dma_iter_ctr.sv
module dma_iter_ctr
  import dmaseq_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int CH_W   = 4,
  parameter int OWN_CH = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] biter,
  input  logic             minor_end,
  input  logic             major_irq_en,
  input  logic             half_irq_en,
  input  logic [1:0]       link_mode,
  input  logic [CH_W-1:0]  link_ch,
  input  logic             cont_link,
  input  logic             done_clr,
  output logic [CNT_W-1:0] citer,
  output logic             done,
  output logic             irq_major,
  output logic             irq_half,
  output logic             link_start,
  output logic [CH_W-1:0]  link_ch_out,
  output logic             major_end,
  output logic             again
);
  logic [CNT_W-1:0] citer_q, citer_dec, half_pt;
  logic             exhaust, link_fire;

  assign exhaust   = (citer_q <= CNT_W'(1));
  assign citer_dec = citer_q - CNT_W'(1);
  assign half_pt   = biter >> 1;
  assign major_end = minor_end && exhaust;
  assign again     = cont_link && (link_mode == LINK_MINOR) &&
                     (link_ch == CH_W'(OWN_CH)) && !exhaust;
  assign link_fire = minor_end && ((link_mode == LINK_MINOR) ||
                                   ((link_mode == LINK_MAJOR) && exhaust));
  assign citer = citer_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      citer_q     <= '0;
      done        <= 1'b0;
      irq_major   <= 1'b0;
      irq_half    <= 1'b0;
      link_start  <= 1'b0;
      link_ch_out <= '0;
    end else begin
      if (load)           citer_q <= biter;
      else if (minor_end) citer_q <= exhaust ? biter : citer_dec;

      if (major_end)     done <= 1'b1;
      else if (done_clr) done <= 1'b0;

      irq_major  <= major_end && major_irq_en;
      irq_half   <= minor_end && !exhaust && half_irq_en &&
                    (half_pt != '0) && (citer_dec == half_pt);
      link_start <= link_fire;
      if (link_fire) link_ch_out <= link_ch;
    end
  end

  assert_count_down_R4: assert property (@(posedge clk) disable iff (!rst_n)
    minor_end && !load && citer_q > CNT_W'(1) |=> citer_q == $past(citer_q) - CNT_W'(1));
  assert_reload_R5: assert property (@(posedge clk) disable iff (!rst_n)
    major_end && !load |=> citer_q == $past(biter) && done);
  assert_done_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done && !done_clr |=> done);
endmodule

// File: rtl/dma_req_ctl.sv
module dma_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_start,
  input  logic hw_req,
  input  logic erq_set,
  input  logic erq_clr,
  input  logic auto_stop,
  input  logic major_end,
  input  logic err_in,
  input  logic halt_on_err,
  input  logic halt_clr,
  input  logic idle,
  output logic req_en,
  output logic halted,
  output logic start_go
);
  assign start_go = idle && !halted && (sw_start || (hw_req && req_en));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_en <= 1'b0;
      halted <= 1'b0;
    end else begin
      if ((major_end && auto_stop) || erq_clr) req_en <= 1'b0;
      else if (erq_set)                        req_en <= 1'b1;

      if (err_in && halt_on_err) halted <= 1'b1;
      else if (halt_clr)         halted <= 1'b0;
    end
  end

  assert_autostop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    major_end && auto_stop |=> !req_en);
  assert_halt_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_in && halt_on_err |=> halted);
endmodule

// File: rtl/dma_loop_seq.sv
module dma_loop_seq
  import dmaseq_pkg::*;
#(
  parameter int NB_W       = 16,
  parameter int CNT_W      = 16,
  parameter int CH_W       = 4,
  parameter int OWN_CH     = 3,
  parameter int BEAT_BYTES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NB_W-1:0]  cfg_nbytes,
  input  logic [CNT_W-1:0] cfg_biter,
  input  logic [1:0]       cfg_bwc,
  input  logic [1:0]       cfg_link_mode,
  input  logic [CH_W-1:0]  cfg_link_ch,
  input  logic             cfg_cont_link,
  input  logic             cfg_auto_stop,
  input  logic             cfg_major_irq_en,
  input  logic             cfg_half_irq_en,
  input  logic             cfg_halt_on_err,
  input  logic             iter_load,
  input  logic             sw_start,
  input  logic             hw_req,
  input  logic             erq_set,
  input  logic             erq_clr,
  input  logic             done_clr,
  input  logic             halt_clr,
  input  logic             err_in,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic             wr_valid,
  input  logic             wr_ready,
  output logic             busy,
  output logic             req_en,
  output logic             halted,
  output logic [CNT_W-1:0] citer,
  output logic             done,
  output logic             irq_major,
  output logic             irq_half,
  output logic             link_start,
  output logic [CH_W-1:0]  link_ch_out
);
  logic start_go, minor_end, major_end, again;

  dma_req_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .hw_req(hw_req),
    .erq_set(erq_set), .erq_clr(erq_clr), .auto_stop(cfg_auto_stop),
    .major_end(major_end), .err_in(err_in), .halt_on_err(cfg_halt_on_err),
    .halt_clr(halt_clr), .idle(!busy), .req_en(req_en), .halted(halted),
    .start_go(start_go)
  );

  dma_beat_engine #(.NB_W(NB_W), .BEAT_BYTES(BEAT_BYTES)) u_engine (
    .clk(clk), .rst_n(rst_n), .start(start_go), .again(again),
    .nbytes(cfg_nbytes), .bwc(cfg_bwc), .rd_valid(rd_valid),
    .rd_ready(rd_ready), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .busy(busy), .minor_end(minor_end)
  );

  dma_iter_ctr #(.CNT_W(CNT_W), .CH_W(CH_W), .OWN_CH(OWN_CH)) u_iter (
    .clk(clk), .rst_n(rst_n), .load(iter_load), .biter(cfg_biter),
    .minor_end(minor_end), .major_irq_en(cfg_major_irq_en),
    .half_irq_en(cfg_half_irq_en), .link_mode(cfg_link_mode),
    .link_ch(cfg_link_ch), .cont_link(cfg_cont_link), .done_clr(done_clr),
    .citer(citer), .done(done), .irq_major(irq_major), .irq_half(irq_half),
    .link_start(link_start), .link_ch_out(link_ch_out),
    .major_end(major_end), .again(again)
  );

  assert_halt_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halted && !busy |=> !busy);
  assert_one_beat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, wr_valid}));
endmodule

// File: tb/test_dma_loop_seq.sv
module test_dma_loop_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_nbytes = 16'd4;
  logic [15:0] cfg_biter = 16'd1;
  logic [1:0]  cfg_bwc = 2'd0, cfg_link_mode = 2'd0;
  logic [3:0]  cfg_link_ch = 4'd0;
  logic cfg_cont_link = 0, cfg_auto_stop = 0, cfg_major_irq_en = 0;
  logic cfg_half_irq_en = 0, cfg_halt_on_err = 0;
  logic iter_load = 0, sw_start = 0, hw_req = 0, erq_set = 0, erq_clr = 0;
  logic done_clr = 0, halt_clr = 0, err_in = 0, rd_ready = 1, wr_ready = 1;
  logic rd_valid, wr_valid, busy, req_en, halted, done;
  logic irq_major, irq_half, link_start;
  logic [15:0] citer;
  logic [3:0]  link_ch_out;

  int checks = 0, failures = 0;
  int n_rd = 0, n_wr = 0, n_busy = 0, n_major = 0, n_half = 0, n_link = 0;

  always #5 clk = ~clk;

  dma_loop_seq i_dma_loop_seq (.*);

  always @(posedge clk) begin
    if (rd_valid && rd_ready) n_rd++;
    if (wr_valid && wr_ready) n_wr++;
    if (busy) n_busy++;
    if (irq_major) n_major++;
    if (irq_half) n_half++;
    if (link_start) n_link++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk); sw_start = 1;
    @(negedge clk); sw_start = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 2000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic load_iter(input int b);
    cfg_biter = 16'(b);
    @(negedge clk); iter_load = 1;
    @(negedge clk); iter_load = 0;
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 valids", {rd_valid, wr_valid}, 0);
    check("R1 flags", {req_en, halted, done}, 0);
    check("R1 pulses", {irq_major, irq_half, link_start}, 0);
    check("R1 citer", citer, 0);
  endtask

  task automatic t_basic();
    int r0, w0, b0, l0, m0;
    cfg_nbytes = 16'd8; cfg_bwc = 0; cfg_link_mode = 2'd1; cfg_link_ch = 4'd5;
    cfg_major_irq_en = 1;
    load_iter(3);
    check("R4 load", citer, 3);
    r0 = n_rd; w0 = n_wr; b0 = n_busy; l0 = n_link; m0 = n_major;
    pulse_start(); wait_idle();
    check("R3 reads", n_rd - r0, 2);
    check("R3 writes", n_wr - w0, 2);
    check("R8 no gap cycles", n_busy - b0, 4);
    check("R4 dec", citer, 2);
    check("R7 minor link", n_link - l0, 1);
    check("R7 link ch", link_ch_out, 5);
    pulse_start(); wait_idle();
    check("R4 dec2", citer, 1);
    check("R5 not done yet", done, 0);
    pulse_start(); wait_idle();
    check("R5 reload", citer, 3);
    check("R5 done", done, 1);
    check("R5 major irq", n_major - m0, 1);
    check("R7 link every loop", n_link - l0, 3);
    repeat (5) @(negedge clk);
    check("R5 done sticky", done, 1);
    done_clr = 1; @(negedge clk); done_clr = 0;
    check("R5 done clear", done, 0);
  endtask

  task automatic t_backpressure();
    int r0;
    cfg_nbytes = 16'd4; cfg_link_mode = 0;
    rd_ready = 0;
    r0 = n_rd;
    pulse_start();
    for (int i = 0; i < 4; i++) begin
      check("R2 rd held", rd_valid, 1);
      @(negedge clk);
    end
    check("R2 no rd hs", n_rd - r0, 0);
    rd_ready = 1; wr_ready = 0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      check("R2 wr held", wr_valid, 1);
      @(negedge clk);
    end
    wr_ready = 1; wait_idle();
    check("R2 one beat", n_rd - r0, 1);
  endtask

  task automatic t_gap(input logic [1:0] code, input int gap);
    int b0;
    cfg_nbytes = 16'd4; cfg_bwc = code;
    b0 = n_busy;
    pulse_start(); wait_idle();
    check($sformatf("R8 gap code %0d", code), n_busy - b0, 2 + 2 * gap);
    cfg_bwc = 0;
  endtask

  task automatic t_half();
    int h0;
    cfg_nbytes = 16'd4; cfg_half_irq_en = 1;
    load_iter(4);
    h0 = n_half;
    pulse_start(); wait_idle();
    check("R6 no half early", n_half - h0, 0);
    pulse_start(); wait_idle();
    check("R6 half", n_half - h0, 1);
    pulse_start(); wait_idle();
    pulse_start(); wait_idle();
    check("R6 half once", n_half - h0, 1);
    cfg_half_irq_en = 0;
  endtask

  task automatic t_link_major();
    int l0;
    cfg_link_mode = 2'd2; cfg_link_ch = 4'd9;
    load_iter(2);
    l0 = n_link;
    pulse_start(); wait_idle();
    check("R7 no link mid", n_link - l0, 0);
    pulse_start(); wait_idle();
    check("R7 major link", n_link - l0, 1);
    check("R7 major link ch", link_ch_out, 9);
    cfg_link_mode = 0;
    pulse_start(); wait_idle();
    check("R7 mode 0", n_link - l0, 1);
  endtask

  task automatic t_hwreq();
    int r0;
    cfg_auto_stop = 1;
    load_iter(1);
    r0 = n_rd;
    @(negedge clk); hw_req = 1; @(negedge clk); hw_req = 0;
    wait_idle();
    check("R3 hw_req ignored w/o enable", n_rd - r0, 0);
    erq_set = 1; @(negedge clk); erq_set = 0;
    check("R9 erq set", req_en, 1);
    @(negedge clk); hw_req = 1; @(negedge clk); hw_req = 0;
    wait_idle();
    check("R3 hw_req starts", n_rd - r0, 1);
    check("R9 auto stop", req_en, 0);
    @(negedge clk); hw_req = 1; @(negedge clk); hw_req = 0;
    wait_idle();
    check("R9 request ignored after stop", n_rd - r0, 1);
    cfg_auto_stop = 0;
  endtask

  task automatic t_cont();
    int r0, m0;
    cfg_cont_link = 1; cfg_link_mode = 2'd1; cfg_link_ch = 4'd3;
    load_iter(3);
    r0 = n_rd; m0 = n_major;
    pulse_start(); wait_idle();
    check("R10 continuous loops", n_rd - r0, 3);
    check("R10 ends at major", n_major - m0, 1);
    check("R10 citer reload", citer, 3);
    cfg_link_ch = 4'd4;
    r0 = n_rd;
    pulse_start(); wait_idle();
    check("R10 other channel no chain", n_rd - r0, 1);
    cfg_cont_link = 0; cfg_link_mode = 0;
  endtask

  task automatic t_halt();
    int r0;
    err_in = 1; @(negedge clk); err_in = 0;
    check("R11 no halt when disabled", halted, 0);
    cfg_halt_on_err = 1;
    err_in = 1; @(negedge clk); err_in = 0;
    check("R11 halted", halted, 1);
    r0 = n_rd;
    pulse_start(); wait_idle();
    check("R11 start ignored", n_rd - r0, 0);
    halt_clr = 1; @(negedge clk); halt_clr = 0;
    check("R11 halt cleared", halted, 0);
    pulse_start(); wait_idle();
    check("R11 start after clear", n_rd - r0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_basic();
    t_backpressure();
    t_gap(2'd0, 0);
    t_gap(2'd1, 0);
    t_gap(2'd2, 4);
    t_gap(2'd3, 8);
    t_half();
    t_link_major();
    t_hwreq();
    t_cont();
    t_halt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures + 1);
    $finish;
  end
endmodule